// File: doc/BRIEF.md
# DMA Transfer Length Controller

This block owns the transfer counter on the DMA side of a SCSI bus controller. Software programs a 24-bit byte count one byte at a time into a staging bank. A command that carries the DMA flag copies the staged value into the live counter. A transfer command then works out how many bytes the coming burst moves. The burst is limited by the live count and by the bytes left in the current bus phase. In command phase the limit is the size of the command buffer.

While the burst runs, each accepted byte handshake lowers the remaining burst length by one. In data phases the same handshake moves the signed phase size one step toward zero. The sign of the phase size gives the direction: negative means bytes flow toward the device. The burst ends in one of three ways: at once, at the end of a device chunk, or after it has waited for the next chunk of device data. When it ends, the block raises terminal count and the bus-service interrupt, clears the counter, and gives a one-cycle done pulse.

Top module: `dtl_ctrl`

## Requirements
- R1: The live count is {high, middle, low}. Staging writes select a byte with `wr_sel`: 0 is low, 1 is middle and 2 is high. A write with `wr_sel` = 3 changes nothing.
- R2: The live counter is loaded from the staged bytes only by a command (`cmd_valid`) with `cmd_dma` = 1. Staging writes and commands with `cmd_dma` = 0 leave it unchanged. Staged bytes persist after a load. A command with both `cmd_dma` and `cmd_xfer` set sizes its burst from the freshly loaded value.
- R3: A live count of zero stands for 65536 bytes when the burst is sized.
- R4: When `cmd_phase` is high, a transfer command (`cmd_xfer` = 1) sizes the burst as min(count, 16). The direction is toward the device.
- R5: In a data phase the burst is min(count, |phase size|). `to_dev` is high exactly when the phase size is negative.
- R6: Starting a burst of nonzero length clears `tc` and `irq_bs`.
- R7: Each accepted byte (`byte_ack` while running) lowers `left_o` by one. In a data phase the same edge moves `size_o` one step toward zero.
- R8: On completion, `done` is high for one cycle. In that cycle `tc` and `irq_bs` are 1, `count_o` and `left_o` are 0, and `busy` is 0. The counter stays 0 until the next load.
- R9: A byte flagged `chunk_end` ends the burst at once if bytes of the burst still remain after it.
- R10: When a `chunk_end` byte is also the last byte of the burst, the burst ends at once if the transfer is toward the device or the phase size has reached zero. Otherwise the block stays busy until `chunk_rdy`, and `done` follows one cycle later. A last byte without `chunk_end` ends the burst at once.
- R11: A transfer command whose burst length is zero completes on the next cycle.
- R12: While busy, commands and size loads are ignored. While idle, `byte_ack` has no effect.
- R13: After reset, count, burst length, phase size, `busy`, `done`, `tc` and `irq_bs` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Staging byte write strobe |
| wr_sel | input | 2 | Staging byte select (0 low, 1 middle, 2 high) |
| wr_data | input | 8 | Staging byte value |
| cmd_valid | input | 1 | Command strobe |
| cmd_dma | input | 1 | Command flag: load live counter from staging |
| cmd_xfer | input | 1 | Command flag: start a transfer burst |
| cmd_phase | input | 1 | Bus is in command phase (sampled at start) |
| size_load | input | 1 | Load phase size while idle |
| size_val | input | 25 | Signed phase size, negative toward device |
| byte_ack | input | 1 | One byte moved by the DMA handshake |
| chunk_end | input | 1 | This byte empties the current device chunk |
| chunk_rdy | input | 1 | Next device chunk is available |
| count_o | output | 24 | Live transfer counter |
| left_o | output | 24 | Bytes remaining in the burst |
| size_o | output | 25 | Signed remaining phase size |
| to_dev | output | 1 | Burst direction is toward the device |
| busy | output | 1 | Burst in progress or waiting for a chunk |
| done | output | 1 | One-cycle completion pulse |
| tc | output | 1 | Terminal-count status |
| irq_bs | output | 1 | Bus-service interrupt status |

## Verification
Every result comes from a register one edge after its stimulus. Staging writes, counter loads, size loads and the burst length appear one cycle after the write, command or strobe. The `done` pulse appears one cycle after the last byte, after a zero-length start, or after `chunk_rdy`. The bench drives each stimulus for exactly one cycle on a falling edge and samples on the next falling edge. That way each check sees the value of the single rising edge in between. Holds, such as the wait for a chunk and ignored commands, are checked on the cycles straight after the stimulus. The pulse is checked again one cycle later to see that it has dropped.

// File: rtl/dtl_pkg.sv
package dtl_pkg;
  typedef enum logic [1:0] {
    DTL_IDLE = 2'd0,
    DTL_RUN  = 2'd1,
    DTL_WAIT = 2'd2
  } dtl_st_e;
endpackage

// File: rtl/dtl_stage.sv
module dtl_stage #(
  parameter int CW   = 24,
  parameter int SELW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [SELW-1:0] wr_sel,
  input  logic [7:0]      wr_data,
  input  logic            reload,
  input  logic            clear,
  output logic [CW-1:0]   count_q,
  output logic [CW-1:0]   count_nx
);
  localparam int NB = CW / 8;

  logic [CW-1:0] stg_flat;

  generate
    for (genvar b = 0; b < NB; b++) begin : g_byte
      logic [7:0] stg_b;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          stg_b <= '0;
        else if (wr_en && (wr_sel == SELW'(b)))
          stg_b <= wr_data;
      end
      assign stg_flat[b*8 +: 8] = stg_b;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count_q <= '0;
    else if (clear)
      count_q <= '0;
    else if (reload)
      count_q <= stg_flat;
  end

  assign count_nx = reload ? stg_flat : count_q;

  // R1 / R2: a load takes the staged bytes
  a_r1_reload_takes_stage: assert property (@(posedge clk) disable iff (!rst_n)
    (reload && !clear) |=> (count_q == $past(stg_flat)));

  // R2: without load or clear the live counter holds
  a_r2_counter_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload && !clear) |=> $stable(count_q));
endmodule

// File: rtl/dtl_len.sv
module dtl_len #(
  parameter int CW       = 24,
  parameter int SW       = 25,
  parameter int CMDBUF   = 16,
  parameter int ZERO_LEN = 65536
) (
  input  logic [CW-1:0]        count,
  input  logic signed [SW-1:0] size,
  input  logic                 cmd_phase,
  output logic [CW-1:0]        burst,
  output logic                 dir_dev
);
  localparam int MW = (CW + 1 > SW) ? CW + 1 : SW;

  function automatic logic [MW-1:0] eff_count(input logic [CW-1:0] c);
    return (c == '0) ? MW'(ZERO_LEN) : MW'(c);
  endfunction

  function automatic logic [MW-1:0] magnitude(input logic signed [SW-1:0] s);
    logic [SW-1:0] m;
    m = s[SW-1] ? SW'(-s) : SW'(s);
    return MW'(m);
  endfunction

  function automatic logic [MW-1:0] smaller(input logic [MW-1:0] a,
                                            input logic [MW-1:0] b);
    return (a < b) ? a : b;
  endfunction

  logic [MW-1:0] eff;
  logic [MW-1:0] limit;
  logic [MW-1:0] pick;

  assign eff     = eff_count(count);
  assign limit   = cmd_phase ? MW'(CMDBUF) : magnitude(size);
  assign pick    = smaller(eff, limit);
  assign burst   = CW'(pick);
  assign dir_dev = cmd_phase || size[SW-1];

  // R3 / R4 / R5: the burst never exceeds either bound
  always_comb begin
    a_r5_burst_bounded: assert (MW'(burst) <= eff && MW'(burst) <= limit);
  end
endmodule

// File: rtl/dtl_seq.sv
module dtl_seq
  import dtl_pkg::*;
#(
  parameter int CW = 24,
  parameter int SW = 25
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_req,
  input  logic                 size_load,
  input  logic signed [SW-1:0] size_val,
  input  logic [CW-1:0]        burst,
  input  logic                 dir_dev,
  input  logic                 cmd_phase,
  input  logic                 byte_ack,
  input  logic                 chunk_end,
  input  logic                 chunk_rdy,
  output logic                 idle,
  output logic                 finish,
  output logic [CW-1:0]        left_q,
  output logic signed [SW-1:0] size_q,
  output logic                 dir_q,
  output logic                 done_q,
  output logic                 tc_q,
  output logic                 irq_q
);
  localparam logic signed [SW-1:0] ONE = SW'(1);

  dtl_st_e st;
  logic    cmd_q;

  logic                 start_take;
  logic                 ack_take;
  logic [CW-1:0]        left_nx;
  logic signed [SW-1:0] size_nx;
  logic                 fin_ack;
  logic                 wait_go;
  logic                 zero_start;

  assign idle       = (st == DTL_IDLE);
  assign start_take = idle && start_req;
  assign zero_start = start_take && (burst == '0);
  assign ack_take   = (st == DTL_RUN) && byte_ack;
  assign left_nx    = left_q - CW'(1);

  always_comb begin
    if (cmd_q || size_q == '0)
      size_nx = size_q;
    else if (size_q < 0)
      size_nx = size_q + ONE;
    else
      size_nx = size_q - ONE;
  end

  assign fin_ack = ack_take &&
                   (chunk_end ? (dir_q || left_nx != '0 || size_nx == '0)
                              : (left_nx == '0));
  assign wait_go = ack_take && chunk_end && !fin_ack;
  assign finish  = fin_ack || zero_start || (st == DTL_WAIT && chunk_rdy);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= DTL_IDLE;
      left_q <= '0;
      size_q <= '0;
      dir_q  <= 1'b0;
      cmd_q  <= 1'b0;
      done_q <= 1'b0;
      tc_q   <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      done_q <= finish;
      if (ack_take)
        size_q <= size_nx;
      else if (idle && size_load && !start_req)
        size_q <= size_val;
      if (finish) begin
        st     <= DTL_IDLE;
        left_q <= '0;
        tc_q   <= 1'b1;
        irq_q  <= 1'b1;
        if (start_take) begin
          dir_q <= dir_dev;
          cmd_q <= cmd_phase;
        end
      end else if (start_take) begin
        st     <= DTL_RUN;
        left_q <= burst;
        dir_q  <= dir_dev;
        cmd_q  <= cmd_phase;
        tc_q   <= 1'b0;
        irq_q  <= 1'b0;
      end else if (wait_go) begin
        st     <= DTL_WAIT;
        left_q <= left_nx;
      end else if (ack_take) begin
        left_q <= left_nx;
      end
    end
  end

  a_r7_ack_decrements: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_take && !finish) |=> (left_q == $past(left_q) - CW'(1)));

  a_r12_idle_holds_left: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !start_take) |=> $stable(left_q));

  a_r6_start_clears_status: assert property (@(posedge clk) disable iff (!rst_n)
    (start_take && burst != '0) |=> (!tc_q && !irq_q));

  a_r11_zero_len_done: assert property (@(posedge clk) disable iff (!rst_n)
    zero_start |=> done_q);

  a_r8_done_state: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (idle && left_q == '0 && tc_q && irq_q));

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !start_take) |=> !done_q);
endmodule

// File: rtl/dtl_ctrl.sv
module dtl_ctrl #(
  parameter int CW       = 24,
  parameter int SW       = 25,
  parameter int CMDBUF   = 16,
  parameter int ZERO_LEN = 65536,
  localparam int NB      = CW / 8,
  localparam int SELW    = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [SELW-1:0]      wr_sel,
  input  logic [7:0]           wr_data,
  input  logic                 cmd_valid,
  input  logic                 cmd_dma,
  input  logic                 cmd_xfer,
  input  logic                 cmd_phase,
  input  logic                 size_load,
  input  logic signed [SW-1:0] size_val,
  input  logic                 byte_ack,
  input  logic                 chunk_end,
  input  logic                 chunk_rdy,
  output logic [CW-1:0]        count_o,
  output logic [CW-1:0]        left_o,
  output logic signed [SW-1:0] size_o,
  output logic                 to_dev,
  output logic                 busy,
  output logic                 done,
  output logic                 tc,
  output logic                 irq_bs
);
  logic                 idle;
  logic                 finish;
  logic                 reload;
  logic                 start_req;
  logic [CW-1:0]        count_nx;
  logic [CW-1:0]        burst;
  logic                 dir_dev;
  logic signed [SW-1:0] size_q;

  assign reload    = idle && cmd_valid && cmd_dma;
  assign start_req = cmd_valid && cmd_xfer;

  dtl_stage #(.CW(CW), .SELW(SELW)) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .reload   (reload),
    .clear    (finish),
    .count_q  (count_o),
    .count_nx (count_nx)
  );

  dtl_len #(.CW(CW), .SW(SW), .CMDBUF(CMDBUF), .ZERO_LEN(ZERO_LEN)) u_len (
    .count     (count_nx),
    .size      (size_q),
    .cmd_phase (cmd_phase),
    .burst     (burst),
    .dir_dev   (dir_dev)
  );

  dtl_seq #(.CW(CW), .SW(SW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (start_req),
    .size_load (size_load),
    .size_val  (size_val),
    .burst     (burst),
    .dir_dev   (dir_dev),
    .cmd_phase (cmd_phase),
    .byte_ack  (byte_ack),
    .chunk_end (chunk_end),
    .chunk_rdy (chunk_rdy),
    .idle      (idle),
    .finish    (finish),
    .left_q    (left_o),
    .size_q    (size_q),
    .dir_q     (to_dev),
    .done_q    (done),
    .tc_q      (tc),
    .irq_q     (irq_bs)
  );

  assign size_o = size_q;
  assign busy   = !idle;

  // R8: counter is cleared when the done pulse shows
  a_r8_count_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (count_o == '0));

  // R12: a command while busy does not disturb the live counter
  a_r12_busy_cmd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !finish) |=> $stable(count_o));
endmodule

// File: tb/sim_dtl_ctrl.sv
module sim_dtl_ctrl;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               wr_en = 1'b0;
  logic [1:0]         wr_sel = '0;
  logic [7:0]         wr_data = '0;
  logic               cmd_valid = 1'b0;
  logic               cmd_dma = 1'b0;
  logic               cmd_xfer = 1'b0;
  logic               cmd_phase = 1'b0;
  logic               size_load = 1'b0;
  logic signed [24:0] size_val = '0;
  logic               byte_ack = 1'b0;
  logic               chunk_end = 1'b0;
  logic               chunk_rdy = 1'b0;
  logic [23:0]        count_o;
  logic [23:0]        left_o;
  logic signed [24:0] size_o;
  logic               to_dev, busy, done, tc, irq_bs;

  int checks = 0;
  int errors = 0;
  bit reported = 1'b0;

  always #10 clk = ~clk;

  dtl_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cmd_valid(cmd_valid), .cmd_dma(cmd_dma), .cmd_xfer(cmd_xfer),
    .cmd_phase(cmd_phase), .size_load(size_load), .size_val(size_val),
    .byte_ack(byte_ack), .chunk_end(chunk_end), .chunk_rdy(chunk_rdy),
    .count_o(count_o), .left_o(left_o), .size_o(size_o), .to_dev(to_dev),
    .busy(busy), .done(done), .tc(tc), .irq_bs(irq_bs)
  );

  localparam int NV = 9;
  localparam int unsigned VCNT [NV] = '{300, 300, 0, 0, 5, 40, 0, 24'h123456, 65535};
  localparam int          VSIZ [NV] = '{1000, -50, 100000, -20, 7, 7, 0, 70000, -65540};
  localparam bit          VCMD [NV] = '{0, 0, 0, 0, 1, 1, 1, 0, 0};
  localparam int unsigned VEXP [NV] = '{300, 50, 65536, 20, 5, 16, 16, 70000, 65535};
  localparam string       VREQ [NV] = '{"R5", "R5", "R3", "R3", "R4", "R4", "R4", "R5", "R5"};

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic cmd(input bit d, input bit x);
    cmd_valid = 1'b1; cmd_dma = d; cmd_xfer = x;
    step();
    cmd_valid = 1'b0; cmd_dma = 1'b0; cmd_xfer = 1'b0;
  endtask

  task automatic stage(input int unsigned c);
    wr(2'd0, c[7:0]);
    wr(2'd1, c[15:8]);
    wr(2'd2, c[23:16]);
  endtask

  task automatic set_size(input int s);
    size_load = 1'b1; size_val = 25'(s);
    step();
    size_load = 1'b0;
  endtask

  task automatic ack(input bit ce);
    byte_ack = 1'b1; chunk_end = ce;
    step();
    byte_ack = 1'b0; chunk_end = 1'b0;
  endtask

  task automatic chk_done(input string req);
    chk(done == 1'b1, req, "done", done, 1);
    chk(tc == 1'b1 && irq_bs == 1'b1, req, "tc&irq", {tc, irq_bs}, 3);
    chk(count_o == 0 && left_o == 0, req, "count|left", count_o | left_o, 0);
    chk(busy == 1'b0, req, "busy", busy, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    report();
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R13 reset state
    chk(count_o == 0 && left_o == 0 && size_o == 0, "R13", "regs", count_o | left_o, 0);
    chk(!busy && !done && !tc && !irq_bs, "R13", "flags", {busy, done, tc, irq_bs}, 0);

    // Table walk: burst sizing, direction, then partial-chunk completion (R9)
    for (int i = 0; i < NV; i++) begin
      stage(VCNT[i]);
      cmd(1'b1, 1'b0);
      chk(count_o == 24'(VCNT[i]), "R1", "count_o", count_o, VCNT[i]);
      set_size(VSIZ[i]);
      cmd_phase = VCMD[i];
      cmd(1'b0, 1'b1);
      cmd_phase = 1'b0;
      chk(left_o == 24'(VEXP[i]), VREQ[i], "left_o", left_o, VEXP[i]);
      chk(to_dev == (VCMD[i] || VSIZ[i] < 0), VREQ[i], "to_dev", to_dev, (VCMD[i] || VSIZ[i] < 0));
      chk(busy == 1'b1 && tc == 1'b0, "R6", "busy/tc", {busy, tc}, 2);
      ack(1'b1);
      chk_done("R9");
    end

    // R2/R1: staging alone and non-load commands leave the counter; sel 3 ignored
    wr(2'd0, 8'h11);
    chk(count_o == 0, "R2", "count after staging", count_o, 0);
    cmd(1'b0, 1'b0);
    chk(count_o == 0, "R2", "count after non-dma cmd", count_o, 0);
    wr(2'd3, 8'h77);
    cmd(1'b1, 1'b0);
    chk(count_o == 24'h00FF11, "R1", "sel3 ignored", count_o, 24'h00FF11);

    // R2: combined load+transfer sizes from the new value
    stage(10);
    set_size(1000);
    cmd(1'b1, 1'b1);
    chk(left_o == 10 && count_o == 10, "R2", "combined left", left_o, 10);
    ack(1'b0);
    chk(left_o == 9, "R7", "left after ack", left_o, 9);
    chk(size_o == 999, "R7", "size after ack", size_o, 999);
    // R12: size load, load and start while busy are ignored
    set_size(5);
    chk(size_o == 999, "R12", "size while busy", size_o, 999);
    wr(2'd0, 8'h33);
    cmd(1'b1, 1'b1);
    chk(count_o == 10 && left_o == 9, "R12", "count while busy", count_o, 10);
    for (int k = 0; k < 8; k++) ack(1'b0);
    chk(left_o == 1 && busy, "R7", "left before last", left_o, 1);
    ack(1'b0);
    chk_done("R8");
    chk(size_o == 990, "R8", "size at end", size_o, 990);
    step();
    chk(done == 1'b0, "R8", "done pulse width", done, 0);
    chk(count_o == 0, "R8", "count held zero", count_o, 0);

    // R6 + R7 negative size + R9 toward device
    stage(4);
    cmd(1'b1, 1'b0);
    set_size(-10);
    cmd(1'b0, 1'b1);
    chk(tc == 1'b0 && irq_bs == 1'b0, "R6", "status cleared", {tc, irq_bs}, 0);
    chk(left_o == 4 && to_dev, "R5", "left/dir", left_o, 4);
    ack(1'b0);
    chk(size_o == -9 && left_o == 3, "R7", "neg size step", size_o, -9);
    ack(1'b1);
    chk_done("R9");

    // R10: from device, size left nonzero -> wait for chunk_rdy
    stage(3);
    cmd(1'b1, 1'b0);
    set_size(10);
    cmd(1'b0, 1'b1);
    ack(1'b0);
    ack(1'b0);
    ack(1'b1);
    chk(busy && !done, "R10", "waiting", {busy, done}, 2);
    chk(left_o == 0 && size_o == 7, "R10", "size while waiting", size_o, 7);
    repeat (3) step();
    chk(busy && !done, "R10", "still waiting", {busy, done}, 2);
    chunk_rdy = 1'b1;
    step();
    chunk_rdy = 1'b0;
    chk_done("R10");

    // R10: phase size reaches zero -> immediate
    stage(3);
    cmd(1'b1, 1'b0);
    set_size(3);
    cmd(1'b0, 1'b1);
    ack(1'b0);
    ack(1'b0);
    ack(1'b1);
    chk_done("R10");

    // R10: toward device -> immediate
    stage(2);
    cmd(1'b1, 1'b0);
    set_size(-10);
    cmd(1'b0, 1'b1);
    ack(1'b0);
    ack(1'b1);
    chk_done("R10");

    // R11: zero-length burst in data phase
    stage(5);
    cmd(1'b1, 1'b0);
    set_size(0);
    cmd(1'b0, 1'b1);
    chk_done("R11");

    // R12: ack while idle has no effect
    ack(1'b1);
    chk(left_o == 0 && !done && !busy, "R12", "idle ack", {left_o, done}, 0);

    report();
  end
endmodule